// File: doc/BRIEF.md
# Write-Leveling Delay Search Engine

This block runs the write-leveling calibration for four byte lanes of a DDR3 data bus, all at once. When enabled, it first holds an entry period with the strobe pins turned to output. It then sends single strobe pulses and reads back, on each lane's lowest data bit, what the memory device sampled on its clock at the strobe edge. A coarse sweep steps every lane's delay across one clock cycle in eighth-cycle increments. For each lane it finds the first coarse step at which the feedback goes from 0 to 1. A fine sweep then walks from the last coarse point that returned 0, in 1/256-cycle steps, until the feedback reads 1.

The delay-line driver uses the per-lane offset outputs, which are in 1/256-cycle units. It applies them whenever the block pulses `meas_upd`. A per-lane composed total adds a preset whole-cycle count and a half-cycle bit to the found offset. When every lane has either finished or failed, the block asks its controller to drop the enable.

There is no data stream in or out of this block, so all pins are plain control and status levels or pulses, with no handshake.

Top module: `wlvl_search`

## Requirements
- R1: After reset, `dqs_oe`, `dqs_strobe`, `meas_upd`, `en_clear`, `lane_err`, `lane_off` and `lane_total` are all zero.
- R2: Count the rising edge that first samples `wl_en` high as edge 1. From that edge, `dqs_oe` is high and no strobe is sent for 40 cycles. The first one-cycle `dqs_strobe` appears after edge 41. `meas_upd` is high in the last cycle of that wait.
- R3: Each probe is a `dqs_strobe` one cycle wide. Feedback is sampled in the 16th cycle after the strobe cycle. Successive coarse strobes are therefore 17 cycles apart.
- R4: The coarse sweep makes exactly 8 probes per lane. It runs with `lane_off` at 0, 32, 64, …, 224, and the value is raised by 32 after each of the first 7 probes.
- R5: The feedback for lane L is bit 8·L of `dq_fb` (bits 0, 8, 16, 24). No other bit of `dq_fb` affects any result.
- R6: With monotone feedback that turns 1 at offset T (1 ≤ T ≤ 224), the fine sweep starts one step above the last coarse 0. The lane ends with `lane_off` = T and `lane_err` = 0.
- R7: A lane whose 8 coarse samples hold no 0-to-1 transition ends with `lane_err` = 1 and `lane_off` = 0.
- R8: A lane whose fine sweep reaches the next coarse boundary (base + 32) and still reads 0 there ends with `lane_err` = 1 and `lane_off` = 0.
- R9: Lanes are searched in parallel. A lane that finishes early holds its offset while the others continue. Completion comes only when all lanes are finished or failed.
- R10: On completion, `en_clear` is high for one cycle, together with a final `meas_upd`, and `dqs_oe` is low in the next cycle. `meas_upd` pulses once at the entry, once per coarse step, once per fine round in which any lane is still searching, and once at the end. That totals 9 + R, where R is the largest number of fine probes any lane needs.
- R11: `lane_total` for lane L is 256·cyc + 128·half + offset, saturated at 736 (2.875 cycles). Here `cyc_preset[2L+1:2L]` and `half_preset[L]` are captured when the run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wl_en | input | 1 | Calibration enable; a run starts when it is seen high while idle |
| cyc_preset | input | 8 | Whole-cycle preset, 2 bits per lane |
| half_preset | input | 4 | Half-cycle preset, 1 bit per lane |
| dq_fb | input | 32 | Data bus feedback from the memory device |
| dqs_oe | output | 1 | Strobe pins driven as outputs while a run is active |
| dqs_strobe | output | 1 | One-cycle strobe probe pulse |
| meas_upd | output | 1 | Force-measure pulse to the delay lines |
| en_clear | output | 1 | One-cycle request to clear the enable at completion |
| lane_err | output | 4 | Per-lane search failure flag |
| lane_off | output | 32 | Per-lane delay offset in 1/256 cycle, 8 bits per lane |
| lane_total | output | 40 | Per-lane composed delay in 1/256 cycle, 10 bits per lane |

## Verification
The assertions assume that `wl_en` stays high from the start edge until `en_clear`. They also assume the feedback bit is steady in the cycle where it is sampled, since it is a slow, settled echo of the last strobe. The stimulus meets both conditions: the bench computes the feedback combinationally from the lane's current offset and a per-lane threshold, and it lowers `wl_en` only after it sees `en_clear`. To reach the fine-boundary failure, one lane's feedback is forced to 0 once the coarse probes are over. This breaks monotonicity on purpose, and only for that lane.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTRY, ST_PULSE, ST_WAIT, ST_FSET, ST_FCHK, ST_FIN, ST_HOLD
  } wl_state_e;
endpackage

// File: rtl/wlvl_timer.sv
module wlvl_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: a load of a nonzero value is never seen as expired on the next cycle
  assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/wlvl_lane.sv
module wlvl_lane #(
  parameter int OW     = 8,
  parameter int COARSE = 8,
  parameter int KW     = $clog2(COARSE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          c_smp,
  input  logic [KW-1:0] c_idx,
  input  logic          c_step,
  input  logic          f_set,
  input  logic          f_smp,
  input  logic          fb,
  output logic          act,
  output logic          err,
  output logic [OW-1:0] off
);
  localparam int STEP = (1 << OW) / COARSE;

  logic [COARSE-1:0] smp_q;
  logic [OW-1:0]     base_q;
  logic              done_q;
  logic              rise_hit;
  logic [KW-1:0]     rise_idx;
  logic [OW:0]       bound;

  // lowest index i with sample i-1 low and sample i high
  always_comb begin
    rise_hit = 1'b0;
    rise_idx = '0;
    for (int i = COARSE - 1; i >= 1; i--) begin
      if (!smp_q[i-1] && smp_q[i]) begin
        rise_hit = 1'b1;
        rise_idx = KW'(i);
      end
    end
  end

  assign bound = {1'b0, base_q} + (OW+1)'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0; base_q <= '0; off <= '0;
      act <= 1'b0; err <= 1'b0; done_q <= 1'b0;
    end else if (init) begin
      smp_q <= '0; base_q <= '0; off <= '0;
      act <= 1'b0; err <= 1'b0; done_q <= 1'b0;
    end else begin
      if (c_smp)  smp_q[c_idx] <= fb;
      if (c_step) off <= off + OW'(STEP);
      if (f_set) begin
        if (rise_hit) begin
          base_q <= OW'((rise_idx - 1'b1) * STEP);
          off    <= OW'((rise_idx - 1'b1) * STEP + 1);
          act    <= 1'b1;
        end else begin
          err <= 1'b1;
          off <= '0;
        end
      end
      if (f_smp && act) begin
        if (fb) begin
          act    <= 1'b0;
          done_q <= 1'b1;
        end else if ({1'b0, off} == bound) begin
          act <= 1'b0;
          err <= 1'b1;
          off <= '0;
        end else begin
          off <= off + 1'b1;
        end
      end
    end
  end

  // R6/R7/R8: a lane is searching, failed or finished, never two at once
  assert_lane_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act, err, done_q}));
  // R8: the fine walk never passes the next coarse boundary
  assert_fine_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> ({1'b0, off} <= bound && off > base_q));
  // R9: a finished lane holds its offset until the next run
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !init) |=> (done_q && $stable(off)));
endmodule

// File: rtl/wlvl_total.sv
module wlvl_total #(
  parameter int OW      = 8,
  parameter int CW      = 2,
  parameter int TW      = 10,
  parameter int MAX_TOT = 736
) (
  input  logic [CW-1:0] cyc,
  input  logic          half,
  input  logic [OW-1:0] off,
  output logic [TW-1:0] total
);
  localparam int SW = TW + 2;
  logic [SW-1:0] sum;

  always_comb begin
    sum = (SW'(cyc) << OW) + (SW'(half) << (OW - 1)) + SW'(off);
    total = (sum > SW'(MAX_TOT)) ? TW'(MAX_TOT) : sum[TW-1:0];
  end

  // R11: the composed delay never exceeds the physical maximum
  assert_total_cap_R11: assert final (total <= TW'(MAX_TOT));
endmodule

// File: rtl/wlvl_search.sv
module wlvl_search #(
  parameter int LANES     = 4,
  parameter int OW        = 8,
  parameter int CW        = 2,
  parameter int TW        = 10,
  parameter int BYTE_W    = 8,
  parameter int COARSE    = 8,
  parameter int ENTRY_CYC = 40,
  parameter int WAIT_CYC  = 16,
  parameter int MAX_TOT   = 736
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wl_en,
  input  logic [LANES*CW-1:0]    cyc_preset,
  input  logic [LANES-1:0]       half_preset,
  input  logic [LANES*BYTE_W-1:0] dq_fb,
  output logic                   dqs_oe,
  output logic                   dqs_strobe,
  output logic                   meas_upd,
  output logic                   en_clear,
  output logic [LANES-1:0]       lane_err,
  output logic [LANES*OW-1:0]    lane_off,
  output logic [LANES*TW-1:0]    lane_total
);
  import wlvl_pkg::*;

  localparam int KW   = $clog2(COARSE);
  localparam int MAXC = (ENTRY_CYC > WAIT_CYC) ? ENTRY_CYC : WAIT_CYC;
  localparam int TMW  = $clog2(MAXC + 1);

  wl_state_e            st_q;
  logic [KW-1:0]        k_q;
  logic                 fine_q;
  logic [LANES*CW-1:0]  cyc_q;
  logic [LANES-1:0]     half_q;
  logic [LANES-1:0]     act;
  logic                 start, entry_end, smp_now, c_smp, c_step, f_smp, f_set;
  logic                 any_act, t_load, t_exp;
  logic [TMW-1:0]       t_val;

  assign start     = (st_q == ST_IDLE) && wl_en;
  assign entry_end = (st_q == ST_ENTRY) && t_exp;
  assign smp_now   = (st_q == ST_WAIT) && t_exp;
  assign c_smp     = smp_now && !fine_q;
  assign f_smp     = smp_now && fine_q;
  assign c_step    = c_smp && (k_q != KW'(COARSE - 1));
  assign f_set     = (st_q == ST_FSET);
  assign any_act   = |act;

  assign t_load = start || (st_q == ST_PULSE);
  assign t_val  = start ? TMW'(ENTRY_CYC - 1) : TMW'(WAIT_CYC - 1);

  wlvl_timer #(.W(TMW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; k_q <= '0; fine_q <= 1'b0;
      cyc_q <= '0; half_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (wl_en) begin
                    st_q <= ST_ENTRY;
                    cyc_q <= cyc_preset;
                    half_q <= half_preset;
                  end
        ST_ENTRY: if (t_exp) begin
                    st_q <= ST_PULSE; k_q <= '0; fine_q <= 1'b0;
                  end
        ST_PULSE: st_q <= ST_WAIT;
        ST_WAIT:  if (t_exp) begin
                    if (fine_q)                           st_q <= ST_FCHK;
                    else if (k_q == KW'(COARSE - 1))      st_q <= ST_FSET;
                    else begin k_q <= k_q + 1'b1;         st_q <= ST_PULSE; end
                  end
        ST_FSET:  begin st_q <= ST_FCHK; fine_q <= 1'b1; end
        ST_FCHK:  st_q <= any_act ? ST_PULSE : ST_FIN;
        ST_FIN:   st_q <= ST_HOLD;
        ST_HOLD:  if (!wl_en) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign dqs_oe     = (st_q != ST_IDLE) && (st_q != ST_HOLD);
  assign dqs_strobe = (st_q == ST_PULSE);
  assign en_clear   = (st_q == ST_FIN);
  assign meas_upd   = entry_end || c_step || ((st_q == ST_FCHK) && any_act) || en_clear;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wlvl_lane #(.OW(OW), .COARSE(COARSE), .KW(KW)) u_lane (
      .clk(clk), .rst_n(rst_n), .init(entry_end),
      .c_smp(c_smp), .c_idx(k_q), .c_step(c_step),
      .f_set(f_set), .f_smp(f_smp), .fb(dq_fb[g*BYTE_W]),
      .act(act[g]), .err(lane_err[g]), .off(lane_off[g*OW +: OW])
    );
    wlvl_total #(.OW(OW), .CW(CW), .TW(TW), .MAX_TOT(MAX_TOT)) u_total (
      .cyc(cyc_q[g*CW +: CW]), .half(half_q[g]),
      .off(lane_off[g*OW +: OW]), .total(lane_total[g*TW +: TW])
    );
  end

  // R3: a strobe is only ever sent with the strobe pins driven
  assert_strobe_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_strobe |-> dqs_oe);
  // R3: a strobe is one cycle wide
  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_strobe |=> !dqs_strobe);
  // R10: completion carries the final force-measure and releases the pins
  assert_fin_measure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_clear |-> meas_upd);
  assert_fin_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_clear |=> (!dqs_oe && !en_clear));
  // R9: completion never comes while any lane is still searching
  assert_all_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_clear |-> !any_act);
endmodule

// File: tb/test_wlvl_search.sv
module test_wlvl_search;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wl_en = 1'b0;
  logic [7:0]  cyc_preset = '0;
  logic [3:0]  half_preset = '0;
  logic [31:0] dq_fb;
  logic        dqs_oe, dqs_strobe, meas_upd, en_clear;
  logic [3:0]  lane_err;
  logic [31:0] lane_off;
  logic [39:0] lane_total;

  int  checks = 0;
  int  fails = 0;
  int  thr [LANES];
  bit  glitch [LANES];
  logic [7:0] noise = 8'h00;
  int  pulses = 0;
  int  first_n, second_n, meas_cnt, oe_after;
  int  coarse_off [8];

  always #4 clk = ~clk;

  wlvl_search i_wlvl_search (
    .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .cyc_preset(cyc_preset),
    .half_preset(half_preset), .dq_fb(dq_fb), .dqs_oe(dqs_oe),
    .dqs_strobe(dqs_strobe), .meas_upd(meas_upd), .en_clear(en_clear),
    .lane_err(lane_err), .lane_off(lane_off), .lane_total(lane_total)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      dq_fb[l*8 +: 8] = noise;
      if (glitch[l] && pulses > 8) dq_fb[l*8] = 1'b0;
      else                         dq_fb[l*8] = (int'(lane_off[l*8 +: 8]) >= thr[l]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int offv(input int l);
    return int'(lane_off[l*8 +: 8]);
  endfunction

  function automatic int totv(input int l);
    return int'(lane_total[l*10 +: 10]);
  endfunction

  task automatic run_cal();
    int n = 0;
    pulses = 0; meas_cnt = 0; first_n = 0; second_n = 0; oe_after = -1;
    @(negedge clk); wl_en = 1'b1;
    forever begin
      @(posedge clk); #1; n++;
      if (meas_upd) meas_cnt++;
      if (dqs_strobe) begin
        if (pulses < 8) coarse_off[pulses] = offv(0);
        pulses++;
        if (pulses == 1) first_n = n;
        if (pulses == 2) second_n = n;
      end
      if (en_clear) break;
    end
    @(posedge clk); #1; oe_after = dqs_oe;
    wl_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(dqs_oe == 0 && dqs_strobe == 0 && meas_upd == 0 && en_clear == 0, "R1 controls", 0, 0);
    chk(lane_err == 0 && lane_off == 0 && lane_total == 0, "R1 lane outputs", 0, 0);
  endtask

  task automatic t_basic();
    thr[0] = 40; thr[1] = 64; thr[2] = 1; thr[3] = 224;
    for (int l = 0; l < LANES; l++) glitch[l] = 0;
    noise = 8'hFE; cyc_preset = '0; half_preset = '0;
    run_cal();
    chk(first_n == 41, "R2 first strobe edge", first_n, 41);
    chk(second_n - first_n == 17, "R3 strobe spacing", second_n - first_n, 17);
    for (int k = 0; k < 8; k++)
      chk(coarse_off[k] == 32 * k, "R4 coarse offset", coarse_off[k], 32 * k);
    for (int l = 0; l < LANES; l++) begin
      chk(offv(l) == thr[l], "R6 found offset", offv(l), thr[l]);
      chk(lane_err[l] == 0, "R6 no error", lane_err[l], 0);
    end
    chk(offv(2) == 1, "R9 early lane holds", offv(2), 1);
    chk(meas_cnt == 41, "R10 force-measure count", meas_cnt, 41);
    chk(oe_after == 0, "R10 pins released", oe_after, 0);
    chk(offv(0) == 40, "R5 noise bits ignored", offv(0), 40);
  endtask

  task automatic t_errors();
    thr[0] = 0; thr[1] = 300; thr[2] = 100; thr[3] = 50;
    glitch[0] = 0; glitch[1] = 0; glitch[2] = 1; glitch[3] = 0;
    noise = 8'h00;
    run_cal();
    chk(lane_err[0] == 1 && offv(0) == 0, "R7 all-ones lane", offv(0), 0);
    chk(lane_err[1] == 1 && offv(1) == 0, "R7 all-zeros lane", offv(1), 0);
    chk(lane_err[2] == 1 && offv(2) == 0, "R8 fine boundary", offv(2), 0);
    chk(lane_err[3] == 0 && offv(3) == 50, "R9 good lane beside failures", offv(3), 50);
    glitch[2] = 0;
  endtask

  task automatic t_total();
    thr[0] = 10; thr[1] = 200; thr[2] = 100; thr[3] = 5;
    cyc_preset = {2'd3, 2'd2, 2'd1, 2'd0};
    half_preset = 4'b0110;
    noise = 8'h5A;
    run_cal();
    chk(totv(0) == 10, "R11 lane0 total", totv(0), 10);
    chk(totv(1) == 584, "R11 lane1 total", totv(1), 584);
    chk(totv(2) == 736, "R11 lane2 saturate", totv(2), 736);
    chk(totv(3) == 736, "R11 lane3 saturate", totv(3), 736);
    chk(offv(1) == 200, "R5 noise bits ignored", offv(1), 200);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin thr[l] = 0; glitch[l] = 0; end
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_basic();
    t_errors();
    t_total();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule